// File: doc/BRIEF.md
# Buffer Descriptor Ring Walker

This block steps through a circular ring of buffer descriptors kept in descriptor memory. Each descriptor is four 16-bit words. For each position the walker first reads the status word and tests its ownership flag. If the controller owns the entry, the walker reads the buffer address and the negative byte count. It then starts a data-mover stub and waits for the stub to finish. Next it writes back the completion information and hands the entry back to the host by clearing the ownership flag. Finally it moves on to the next index, which wraps at the ring size.

Two configuration words give the ring base and its size code. One instance serves one direction. The parameter `IS_TX` picks the transmit variant (1) or the receive variant (0).

The descriptor memory port has one cycle of read latency: `mem_rdata` holds the addressed word in the cycle after `mem_rd`. Writes take effect at the clock edge where `mem_wr` is high.

Top module: `ring_walker`

## Requirements
- R1: On `cfg_load` the ring base becomes `{cfg_ptr_hi[7:0], cfg_ptr_lo[15:3], 3'b000}` and the size code becomes `cfg_ptr_hi[15:13]`. Descriptor k lives at byte address base + 8k, and its word j (0 to 3) lives at that address + 2j.
- R2: A descriptor whose word 1 has bit 15 at 0 is owned by the host. For such a descriptor the walker starts no transfer, writes nothing and keeps its index, then waits. A `poll` pulse in the waiting state makes it fetch word 1 again. After reset or a load the walker waits for a `poll`.
- R3: For an owned descriptor the walker gives the mover the buffer address `{word1[7:0], word0}` and the length `4096 - word2[11:0]` (13 bits). It does so with a `mv_start` pulse that lasts one cycle.
- R4: After `mv_done`, word 1 is rewritten with bit 15 cleared and the buffer address byte in bits 7:0 unchanged. The write of word 1 is the last write for that descriptor.
- R5: After each write of word 1 the index advances by one modulo 2^code, where code 0 gives a ring of one entry and code 7 gives 128 entries. The walker then fetches the next descriptor without waiting for a `poll`.
- R6: Receive: word 3 is written as `{4'b0000, mv_count}`.
- R7: Receive: word 1 bits 13, 12, 11 and 10 take `mv_err[3]`, `mv_err[2]`, `mv_err[1]` and `mv_err[0]`, standing for framing, overflow, CRC and buffer error. Bit 14 is the OR of those four bits, and `mv_err[4]` is ignored.
- R8: Receive: word 1 bit 9 is set when the buffer is the first one of a frame, meaning it is the first after a load or it follows a buffer that had `mv_last`. Bit 8 equals `mv_last`. `mv_sop` shows the same first-buffer flag during the transfer.
- R9: Transmit: `mv_sop` and `mv_eop` show word 1 bits 9 and 8, and the write-back keeps those two bits. Bits 12:10 are written as 0 and bit 14 is the OR of `mv_err[4:0]`.
- R10: Transmit: when `mv_err` is non-zero, word 3 becomes bit15=`mv_err[4]` (buffer), bit14=`mv_err[3]|mv_err[4]` (underflow, forced by a buffer error), bit12=`mv_err[2]` (late collision), bit11=`mv_err[1]` (carrier loss) and bit10=`mv_err[0]` (retries exhausted), with every other bit 0. When `mv_err` is zero, word 3 is left unwritten.
- R11: Reset and `cfg_load` both set the index to 0, clear the receive frame tracking and return the walker to the waiting state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Load ring configuration |
| cfg_ptr_lo | input | 16 | Ring base bits 15:3 (bits 2:0 ignored) |
| cfg_ptr_hi | input | 16 | Size code in 15:13, base bits 23:16 in 7:0 |
| poll | input | 1 | Re-poll strobe while waiting |
| mem_rd | output | 1 | Descriptor memory read |
| mem_wr | output | 1 | Descriptor memory write |
| mem_addr | output | 24 | Descriptor memory byte address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid one cycle after `mem_rd` |
| mv_start | output | 1 | One-cycle transfer start |
| mv_addr | output | 24 | Buffer address |
| mv_len | output | 13 | Buffer length in bytes |
| mv_sop | output | 1 | First buffer of frame |
| mv_eop | output | 1 | Last buffer of frame (transmit) |
| mv_done | input | 1 | Transfer finished, status inputs valid |
| mv_count | input | 12 | Receive byte count |
| mv_last | input | 1 | Receive frame ended in this buffer |
| mv_err | input | 5 | Error flags of the transfer |
| ring_idx | output | 7 | Current ring index |

## Verification
The assertions assume three things about the inputs. Descriptor memory answers every read exactly one cycle later. `mv_done` arrives once per `mv_start` and only while a transfer is outstanding. Configuration changes only while the walker is idle or is being loaded afresh. The bench keeps to these assumptions with a fixed-latency memory model and a mover responder that answers each start with exactly one done pulse. The host writes to descriptors only while the walker waits on a host-owned entry. Random buffer addresses, byte counts, frame ends and error patterns are combined with directed cases: a host-owned first entry, a buffer error alone, an error-free transmit and a one-entry ring.

// File: rtl/ring_walker.sv
module ring_walker #(
  parameter bit IS_TX = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_load,
  input  logic [15:0] cfg_ptr_lo,
  input  logic [15:0] cfg_ptr_hi,
  input  logic        poll,
  output logic        mem_rd,
  output logic        mem_wr,
  output logic [23:0] mem_addr,
  output logic [15:0] mem_wdata,
  input  logic [15:0] mem_rdata,
  output logic        mv_start,
  output logic [23:0] mv_addr,
  output logic [12:0] mv_len,
  output logic        mv_sop,
  output logic        mv_eop,
  input  logic        mv_done,
  input  logic [11:0] mv_count,
  input  logic        mv_last,
  input  logic [4:0]  mv_err,
  output logic [6:0]  ring_idx
);
  localparam int AW = 24;
  localparam int IW = 7;

  typedef enum logic [3:0] {
    S_WAIT, S_RD1, S_CHK, S_GET0, S_GET2, S_GO, S_BUSY, S_WB3, S_WB1
  } st_t;

  st_t           st;
  logic [AW-1:0] base, dbase;
  logic [2:0]    rcode;
  logic [IW-1:0] idx, mask;
  logic [15:0]   w0, w1, w2;
  logic [11:0]   cnt_q;
  logic          last_q;
  logic [4:0]    err_q;
  logic          in_frame;
  logic [15:0]   wb1, wb3;
  logic          wr3_en;
  logic          unused_cfg;

  assign unused_cfg = ^{cfg_ptr_lo[2:0], cfg_ptr_hi[12:8], w2[15:12], w1[15:10]};
  assign mask       = IW'((8'd1 << rcode) - 8'd1);
  assign dbase      = base + AW'({idx, 3'b000});
  assign ring_idx   = idx;
  assign mv_start   = (st == S_GO);
  assign mv_addr    = {w1[7:0], w0};
  assign mv_len     = 13'h1000 - {1'b0, w2[11:0]};

  generate
    if (IS_TX) begin : g_tx
      logic unused_tx;
      assign unused_tx = ^{cnt_q, last_q, in_frame};
      assign wb1    = {1'b0, |err_q, 1'b0, 3'b000, w1[9:8], w1[7:0]};
      assign wb3    = {err_q[4], err_q[4] | err_q[3], 1'b0, err_q[2:0], 10'd0};
      assign wr3_en = |err_q;
      assign mv_sop = w1[9];
      assign mv_eop = w1[8];
    end else begin : g_rx
      logic unused_rx;
      assign unused_rx = ^{err_q[4], w1[9:8]};
      assign wb1    = {1'b0, |err_q[3:0], err_q[3:0], ~in_frame, last_q, w1[7:0]};
      assign wb3    = {4'b0000, cnt_q};
      assign wr3_en = 1'b1;
      assign mv_sop = ~in_frame;
      assign mv_eop = 1'b0;
    end
  endgenerate

  always_comb begin
    mem_rd    = 1'b0;
    mem_wr    = 1'b0;
    mem_addr  = dbase;
    mem_wdata = wb1;
    case (st)
      S_RD1:  begin mem_rd = 1'b1; mem_addr = dbase + AW'(2); end
      S_CHK:  mem_rd = mem_rdata[15];
      S_GET0: begin mem_rd = 1'b1; mem_addr = dbase + AW'(4); end
      S_WB3:  begin mem_wr = wr3_en; mem_addr = dbase + AW'(6); mem_wdata = wb3; end
      S_WB1:  begin mem_wr = 1'b1; mem_addr = dbase + AW'(2); end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_WAIT;
      base     <= '0;
      rcode    <= '0;
      idx      <= '0;
      in_frame <= 1'b0;
      w0       <= '0;
      w1       <= '0;
      w2       <= '0;
      cnt_q    <= '0;
      last_q   <= 1'b0;
      err_q    <= '0;
    end else if (cfg_load) begin
      base     <= {cfg_ptr_hi[7:0], cfg_ptr_lo[15:3], 3'b000};
      rcode    <= cfg_ptr_hi[15:13];
      idx      <= '0;
      in_frame <= 1'b0;
      st       <= S_WAIT;
    end else begin
      case (st)
        S_WAIT: if (poll) st <= S_RD1;
        S_RD1:  st <= S_CHK;
        S_CHK:  if (mem_rdata[15]) begin
                  w1 <= mem_rdata;
                  st <= S_GET0;
                end else begin
                  st <= S_WAIT;
                end
        S_GET0: begin w0 <= mem_rdata; st <= S_GET2; end
        S_GET2: begin w2 <= mem_rdata; st <= S_GO; end
        S_GO:   st <= S_BUSY;
        S_BUSY: if (mv_done) begin
                  cnt_q  <= mv_count;
                  last_q <= mv_last;
                  err_q  <= mv_err;
                  st     <= S_WB3;
                end
        S_WB3:  st <= S_WB1;
        S_WB1:  begin
                  idx      <= (idx + IW'(1)) & mask;
                  in_frame <= ~last_q;
                  st       <= S_RD1;
                end
        default: st <= S_WAIT;
      endcase
    end
  end
endmodule

// File: rtl/ring_walker_chk.sv
module ring_walker_chk #(
  parameter bit IS_TX = 1'b0
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_load,
  input logic        mem_rd,
  input logic        mem_wr,
  input logic [23:0] mem_addr,
  input logic [15:0] mem_wdata,
  input logic        mv_start,
  input logic [6:0]  ring_idx,
  input logic [2:0]  rcode
);
  logic [6:0] cmask;
  assign cmask = 7'((8'd1 << rcode) - 8'd1);

  AST_NO_RDWR_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr)); // R4
  AST_HALFWORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> (mem_addr[0] == 1'b0)); // R1
  AST_IDX_IN_RING: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, ring_idx} < (8'd1 << rcode))); // R5
  AST_OWN_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && mem_addr[2:1] == 2'd1) |-> !mem_wdata[15]); // R4
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    mv_start |=> !mv_start); // R3
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && mem_addr[2:1] == 2'd1 && !cfg_load) |=>
      (ring_idx == (($past(ring_idx) + 7'd1) & cmask))); // R5
  AST_RX_MCNT_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (!IS_TX && mem_wr && mem_addr[2:1] == 2'd3) |-> (mem_wdata[15:12] == 4'd0)); // R6
  AST_TX_BUFF_UFLO: assert property (@(posedge clk) disable iff (!rst_n)
    (IS_TX && mem_wr && mem_addr[2:1] == 2'd3 && mem_wdata[15]) |-> mem_wdata[14]); // R10
endmodule

bind ring_walker ring_walker_chk #(.IS_TX(IS_TX)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mv_start(mv_start),
  .ring_idx(ring_idx), .rcode(rcode)
);

// File: tb/ring_walker_tb.sv
`timescale 1ns/1ps
module ring_walker_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;

  logic        r_load = 0, t_load = 0, r_poll = 0, t_poll = 0;
  logic [15:0] r_plo = 0, r_phi = 0, t_plo = 0, t_phi = 0;
  logic        r_rd, r_wr, t_rd, t_wr;
  logic [23:0] r_ma, t_ma, r_mva, t_mva;
  logic [15:0] r_wd, t_wd, r_rdat = 0, t_rdat = 0;
  logic        r_start, t_start, r_sop, t_sop, r_eop, t_eop;
  logic [12:0] r_len, t_len;
  logic        r_done = 0, t_done = 0, r_lst = 0, t_lst = 0;
  logic [11:0] r_cnt = 0, t_cnt = 0;
  logic [4:0]  r_err = 0, t_err = 0;
  logic [6:0]  r_idx, t_idx;

  ring_walker #(.IS_TX(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_load(r_load), .cfg_ptr_lo(r_plo), .cfg_ptr_hi(r_phi),
    .poll(r_poll), .mem_rd(r_rd), .mem_wr(r_wr), .mem_addr(r_ma), .mem_wdata(r_wd),
    .mem_rdata(r_rdat), .mv_start(r_start), .mv_addr(r_mva), .mv_len(r_len),
    .mv_sop(r_sop), .mv_eop(r_eop), .mv_done(r_done), .mv_count(r_cnt),
    .mv_last(r_lst), .mv_err(r_err), .ring_idx(r_idx));

  ring_walker #(.IS_TX(1'b1)) u_tx (
    .clk(clk), .rst_n(rst_n), .cfg_load(t_load), .cfg_ptr_lo(t_plo), .cfg_ptr_hi(t_phi),
    .poll(t_poll), .mem_rd(t_rd), .mem_wr(t_wr), .mem_addr(t_ma), .mem_wdata(t_wd),
    .mem_rdata(t_rdat), .mv_start(t_start), .mv_addr(t_mva), .mv_len(t_len),
    .mv_sop(t_sop), .mv_eop(t_eop), .mv_done(t_done), .mv_count(t_cnt),
    .mv_last(t_lst), .mv_err(t_err), .ring_idx(t_idx));

  logic [15:0] mem_r [0:511];
  logic [15:0] mem_t [0:511];
  logic        h_we = 0, h_tx = 0;
  logic [8:0]  h_a = 0;
  logic [15:0] h_d = 0;

  always @(posedge clk) begin
    if (r_rd) r_rdat <= mem_r[r_ma[9:1]];
    if (t_rd) t_rdat <= mem_t[t_ma[9:1]];
    if (r_wr) mem_r[r_ma[9:1]] <= r_wd;
    if (t_wr) mem_t[t_ma[9:1]] <= t_wd;
    if (h_we && !h_tx) mem_r[h_a] <= h_d;
    if (h_we && h_tx)  mem_t[h_a] <= h_d;
  end

  logic [11:0] rs_cnt [0:15];
  logic        rs_last[0:15];
  logic [4:0]  rs_err [0:15];
  logic [23:0] r_la [0:15], t_la [0:15];
  logic [12:0] r_ll [0:15], t_ll [0:15];
  logic        r_ls [0:15], t_ls [0:15], t_le [0:15];
  int r_n = 0, t_n = 0, r_w = 0, t_w = 0;

  always @(negedge clk) begin
    r_done = 1'b0;
    if (r_start) begin
      r_la[r_n] = r_mva; r_ll[r_n] = r_len; r_ls[r_n] = r_sop;
      r_n++; r_w = 2;
    end else if (r_w > 0) begin
      r_w--;
      if (r_w == 0) begin
        r_done = 1'b1; r_cnt = rs_cnt[r_n-1]; r_lst = rs_last[r_n-1]; r_err = rs_err[r_n-1];
      end
    end
  end

  always @(negedge clk) begin
    t_done = 1'b0;
    if (t_start) begin
      t_la[t_n] = t_mva; t_ll[t_n] = t_len; t_ls[t_n] = t_sop; t_le[t_n] = t_eop;
      t_n++; t_w = 3;
    end else if (t_w > 0) begin
      t_w--;
      if (t_w == 0) begin
        t_done = 1'b1; t_cnt = rs_cnt[t_n-1]; t_lst = rs_last[t_n-1]; t_err = rs_err[t_n-1];
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hwrite(input bit tx, input int waddr, input logic [15:0] d);
    @(negedge clk); h_we = 1'b1; h_tx = tx; h_a = 9'(waddr); h_d = d;
    @(negedge clk); h_we = 1'b0;
  endtask

  task automatic pulse_poll(input bit tx);
    @(negedge clk); if (tx) t_poll = 1'b1; else r_poll = 1'b1;
    @(negedge clk); t_poll = 1'b0; r_poll = 1'b0;
  endtask

  task automatic load(input bit tx, input logic [15:0] lo, input logic [15:0] hi);
    @(negedge clk);
    if (tx) begin t_plo = lo; t_phi = hi; t_load = 1'b1; end
    else begin r_plo = lo; r_phi = hi; r_load = 1'b1; end
    @(negedge clk); t_load = 1'b0; r_load = 1'b0;
  endtask

  function automatic logic [12:0] len_of(input logic [15:0] w2);
    return 13'h1000 - {1'b0, w2[11:0]};
  endfunction
  function automatic logic [15:0] rx_w1(input logic [7:0] hadr, input logic [3:0] e,
                                        input logic stp, input logic enp);
    return {1'b0, |e, e, stp, enp, hadr};
  endfunction
  function automatic logic [15:0] tx_w1(input logic [15:0] w, input logic [4:0] e);
    return {1'b0, |e, 4'b0000, w[9:8], w[7:0]};
  endfunction
  function automatic logic [15:0] tx_w3(input logic [15:0] old, input logic [4:0] e);
    if (e == 5'd0) return old;
    return {e[4], e[4] | e[3], 1'b0, e[2:0], 10'd0};
  endfunction

  logic [15:0] d0 [0:15];
  logic [15:0] d1 [0:15];
  logic [15:0] d2 [0:15];

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic frame;
    int   wa;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    chk("R11 reset index rx", 32'(r_idx), 32'd0);
    chk("R11 reset index tx", 32'(t_idx), 32'd0);
    chk("R11 reset no access", 32'({r_rd, r_wr, r_start, t_rd, t_wr, t_start}), 32'd0);
    rst_n = 1'b1;

    // receive ring: base 0x100, code 2 (4 entries)
    load(1'b0, 16'h0100, 16'h4000);
    hwrite(1'b0, 16'h81, 16'h0033);
    pulse_poll(1'b0);
    repeat (20) @(negedge clk);
    chk("R2 host-owned no transfer", 32'(r_n), 32'd0);
    chk("R2 host-owned index held", 32'(r_idx), 32'd0);
    chk("R2 host-owned untouched", 32'(mem_r[16'h81]), 32'h0033);

    for (int k = 0; k < 4; k++) begin
      d0[k] = 16'($urandom);
      d1[k] = 16'h8000 | 16'($urandom % 256);
      d2[k] = 16'hF000 | 16'($urandom % 4096);
      rs_cnt[k]  = 12'($urandom);
      rs_last[k] = 1'($urandom);
      rs_err[k]  = ($urandom % 3 == 0) ? 5'($urandom) : 5'd0;
      wa = 16'h80 + 4 * k;
      hwrite(1'b0, wa, d0[k]); hwrite(1'b0, wa + 1, d1[k]);
      hwrite(1'b0, wa + 2, d2[k]); hwrite(1'b0, wa + 3, 16'hFFFF);
    end
    pulse_poll(1'b0);
    repeat (200) @(negedge clk);
    chk("R5 rx ring of 4 processed", 32'(r_n), 32'd4);
    chk("R5 rx index wrapped", 32'(r_idx), 32'd0);
    frame = 1'b0;
    for (int k = 0; k < 4; k++) begin
      wa = 16'h80 + 4 * k;
      chk("R3 rx buffer address", 32'(r_la[k]), 32'({d1[k][7:0], d0[k]}));
      chk("R3 rx buffer length", 32'(r_ll[k]), 32'(len_of(d2[k])));
      chk("R8 rx mv_sop", 32'(r_ls[k]), 32'(!frame));
      chk("R1 R4 R7 R8 rx word1", 32'(mem_r[wa + 1]),
          32'(rx_w1(d1[k][7:0], rs_err[k][3:0], !frame, rs_last[k])));
      chk("R6 rx word3", 32'(mem_r[wa + 3]), {20'd0, rs_cnt[k]});
      frame = !rs_last[k];
    end

    // hand entry 0 back once more, frame ends here
    d1[4] = 16'h80A5; rs_cnt[4] = 12'h040; rs_last[4] = 1'b1; rs_err[4] = 5'b10000;
    hwrite(1'b0, 16'h81, d1[4]);
    pulse_poll(1'b0);
    repeat (60) @(negedge clk);
    chk("R5 rx one more release", 32'(r_n), 32'd5);
    chk("R2 R5 rx waits at host entry", 32'(r_idx), 32'd1);
    chk("R7 R8 rx word1 again", 32'(mem_r[16'h81]), 32'(rx_w1(8'hA5, 4'd0, !frame, 1'b1)));
    chk("R6 rx word3 again", 32'(mem_r[16'h83]), 32'h40);
    load(1'b0, 16'h0100, 16'h4000);
    chk("R11 load resets index", 32'(r_idx), 32'd0);

    // transmit ring: base 0x208, code 3 (8 entries)
    load(1'b1, 16'h0208, 16'h6000);
    for (int k = 0; k < 8; k++) begin
      d0[k] = 16'($urandom);
      d1[k] = 16'h9C00 | 16'(($urandom % 4) << 8) | 16'($urandom % 256);
      d2[k] = 16'hF000 | 16'($urandom % 4096);
      rs_cnt[k] = 12'd0; rs_last[k] = 1'b0;
      if (k % 2 == 0) rs_err[k] = 5'd0;
      else if (k == 1) rs_err[k] = 5'b10000;
      else rs_err[k] = 5'($urandom % 31 + 1);
      wa = 16'h104 + 4 * k;
      hwrite(1'b1, wa, d0[k]); hwrite(1'b1, wa + 1, d1[k]);
      hwrite(1'b1, wa + 2, d2[k]); hwrite(1'b1, wa + 3, 16'hABCD);
    end
    pulse_poll(1'b1);
    repeat (300) @(negedge clk);
    chk("R5 tx ring of 8 processed", 32'(t_n), 32'd8);
    chk("R5 tx index wrapped", 32'(t_idx), 32'd0);
    for (int k = 0; k < 8; k++) begin
      wa = 16'h104 + 4 * k;
      chk("R3 tx buffer address", 32'(t_la[k]), 32'({d1[k][7:0], d0[k]}));
      chk("R3 tx buffer length", 32'(t_ll[k]), 32'(len_of(d2[k])));
      chk("R9 tx sop/eop", 32'({t_ls[k], t_le[k]}), 32'(d1[k][9:8]));
      chk("R1 R4 R9 tx word1", 32'(mem_t[wa + 1]), 32'(tx_w1(d1[k], rs_err[k])));
      chk("R10 tx word3", 32'(mem_t[wa + 3]), 32'(tx_w3(16'hABCD, rs_err[k])));
    end

    // one-entry ring: base 0x300, code 0
    load(1'b1, 16'h0300, 16'h0000);
    d1[8] = 16'h8377; rs_err[8] = 5'b00101; rs_cnt[8] = 0; rs_last[8] = 0;
    hwrite(1'b1, 16'h180, 16'h1234); hwrite(1'b1, 16'h181, d1[8]);
    hwrite(1'b1, 16'h182, 16'hFFFF); hwrite(1'b1, 16'h183, 16'h0000);
    pulse_poll(1'b1);
    repeat (60) @(negedge clk);
    chk("R5 single entry processed once", 32'(t_n), 32'd9);
    chk("R5 single entry index stays", 32'(t_idx), 32'd0);
    chk("R3 length of all-ones count", 32'(t_ll[8]), 32'd1);
    chk("R1 R9 single entry word1", 32'(mem_t[16'h181]), 32'(tx_w1(d1[8], rs_err[8])));
    chk("R10 single entry word3", 32'(mem_t[16'h183]), 32'(tx_w3(16'h0000, rs_err[8])));

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule